// File: doc/BRIEF.md
# Beacon-Triggered Sensor Packet Transmitter

This block is the transmit side of a sensor node. On a valid strobe it captures an 8-bit temperature sample and masks it with an 8-bit key supplied on an input port. It then computes an 8-bit CRC over the masked byte and builds a 16-bit frame from the two. The frame is not sent until the receiver's beacon has been observed. Once sending starts, the frame is shifted out one bit per clock.

After each frame the block listens for an acknowledgment for a fixed window. If the acknowledgment comes, the block raises a one-cycle done pulse and goes back to idle. If it does not come, the frame is sent again. An overall cycle budget, counted from the moment the beacon is seen, limits the attempt. When the budget runs out, a one-cycle timeout pulse is raised and the block returns to idle, even if a frame is only partly sent.

Top module: `snd_tx`

## Requirements
- R1: A synchronous active-high reset returns the block to idle and clears all counters. After reset, ser_o, frame_valid_o, done_o and timeout_o are all low.
- R2: No bit is sent unless a beacon has been sampled high while a captured frame is waiting. The block waits for the beacon indefinitely. A beacon sampled while idle has no effect.
- R3: When in_valid_i is sampled high while idle, the frame body is captured as temp_i XOR key_i.
- R4: The check byte is CRC-8 of the body with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, processed MSB first. The frame is {body, crc}, with the body in bits 15:8.
- R5: frame_valid_o goes high in the cycle after the beacon is sampled and stays high for exactly 16 cycles. ser_o carries frame bit 15 first, then one lower bit per cycle. ser_o is low whenever frame_valid_o is low.
- R6: An acknowledgment sampled high in the listen window raises done_o for exactly one cycle, in the next cycle, and the block returns to idle. An acknowledgment sampled while a frame is being sent is ignored.
- R7: If no acknowledgment arrives within ACK_WAIT listen cycles, the same frame is sent again, starting in the cycle after the window closes.
- R8: Exactly BUDGET cycles after sending starts (frame_valid_o high or listening), timeout_o pulses for one cycle and the block returns to idle, cutting off a frame in progress if needed.
- R9: in_valid_i is ignored outside idle: the captured frame does not change until the block next returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Strobe for temperature and key |
| temp_i | input | 8 | Temperature sample |
| key_i | input | 8 | Masking key |
| beacon_i | input | 1 | Receiver beacon seen |
| ack_i | input | 1 | Acknowledgment from receiver |
| ser_o | output | 1 | Serial frame bit |
| frame_valid_o | output | 1 | High during frame bit times |
| done_o | output | 1 | One-cycle pulse on acknowledgment |
| timeout_o | output | 1 | One-cycle pulse on budget expiry |

## Verification
The bench builds the block with BUDGET = 50 and ACK_WAIT = 4. One frame plus its listen window then takes 20 cycles, so an unanswered attempt fits two full frames and ends with the third frame cut off after ten bits. That makes resending, frame truncation and the exact expiry cycle all observable in a short run. The short window also lets an acknowledgment land well before the budget, so the done path can be tested without any interference from the timeout.

// File: rtl/snd_pkg.sv
package snd_pkg;

    localparam int DATA_W  = 8;
    localparam int CRC_W   = 8;
    localparam int FRAME_W = DATA_W + CRC_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BCN,
        ST_SEND,
        ST_ACK
    } tx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] body;
        logic [CRC_W-1:0]  chk;
    } frame_t;

    // Bit-serial CRC, MSB of the data first, register starts at zero.
    function automatic logic [CRC_W-1:0] crc_calc(input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/snd_cnt.sv
module snd_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (en)     cnt <= last ? '0 : cnt + 1'b1;
    end

    assign last = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/snd_framer.sv
module snd_framer
    import snd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [DATA_W-1:0] temp,
    input  logic [DATA_W-1:0] key,
    output frame_t            frame
);
    logic [DATA_W-1:0] masked;

    assign masked = temp ^ key;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '0;
        end else if (cap) begin
            frame.body <= masked;
            frame.chk  <= crc_calc(masked);
        end
    end

    // R9: the held frame only changes on a capture
    a_r9_frame_hold: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(frame));

endmodule

// File: rtl/snd_shift.sv
module snd_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)        sr <= '0;
        else if (load)  sr <= din;
        else if (shift) sr <= {sr[W-2:0], 1'b0};
    end

    assign msb = sr[W-1];

endmodule

// File: rtl/snd_tx.sv
module snd_tx
    import snd_pkg::*;
#(
    parameter int BUDGET   = 256,
    parameter int ACK_WAIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] temp_i,
    input  logic [DATA_W-1:0] key_i,
    input  logic              beacon_i,
    input  logic              ack_i,
    output logic              ser_o,
    output logic              frame_valid_o,
    output logic              done_o,
    output logic              timeout_o
);
    tx_state_e state, state_nx;
    frame_t    frame;

    logic cap, load, shift_en;
    logic bit_clr, bit_last;
    logic win_clr, win_en, win_last;
    logic bud_clr, bud_en, bud_last;
    logic done_set, tmo_set;
    logic sr_msb;

    always_comb begin
        state_nx = state;
        cap      = 1'b0;
        load     = 1'b0;
        bit_clr  = 1'b0;
        win_clr  = 1'b0;
        bud_clr  = 1'b0;
        done_set = 1'b0;
        tmo_set  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid_i) begin
                    cap      = 1'b1;
                    state_nx = ST_BCN;
                end
            end
            ST_BCN: begin
                if (beacon_i) begin
                    load     = 1'b1;
                    bit_clr  = 1'b1;
                    bud_clr  = 1'b1;
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                if (bud_last) begin
                    tmo_set  = 1'b1;
                    state_nx = ST_IDLE;
                end else if (bit_last) begin
                    win_clr  = 1'b1;
                    state_nx = ST_ACK;
                end
            end
            ST_ACK: begin
                if (ack_i) begin
                    done_set = 1'b1;
                    state_nx = ST_IDLE;
                end else if (bud_last) begin
                    tmo_set  = 1'b1;
                    state_nx = ST_IDLE;
                end else if (win_last) begin
                    load     = 1'b1;
                    bit_clr  = 1'b1;
                    state_nx = ST_SEND;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign shift_en = (state == ST_SEND);
    assign win_en   = (state == ST_ACK);
    assign bud_en   = (state == ST_SEND) || (state == ST_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            state     <= state_nx;
            done_o    <= done_set;
            timeout_o <= tmo_set;
        end
    end

    snd_framer i_framer (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .temp  (temp_i),
        .key   (key_i),
        .frame (frame)
    );

    snd_shift #(.W(FRAME_W)) i_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .shift (shift_en),
        .din   (frame),
        .msb   (sr_msb)
    );

    snd_cnt #(.LIMIT(FRAME_W)) i_bit_cnt (
        .clk (clk), .rst (rst), .clr (bit_clr), .en (shift_en), .last (bit_last)
    );

    snd_cnt #(.LIMIT(ACK_WAIT)) i_win_cnt (
        .clk (clk), .rst (rst), .clr (win_clr), .en (win_en), .last (win_last)
    );

    snd_cnt #(.LIMIT(BUDGET)) i_bud_cnt (
        .clk (clk), .rst (rst), .clr (bud_clr), .en (bud_en), .last (bud_last)
    );

    assign frame_valid_o = (state == ST_SEND);
    assign ser_o         = frame_valid_o & sr_msb;

    // R2: without a beacon the machine stays out of the sending state
    a_r2_beacon_gate: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BCN) && !beacon_i |=> !frame_valid_o);

    // R6: done is a single-cycle pulse and leaves the block idle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: timeout is a single-cycle pulse, never together with done
    a_r8_tmo_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    a_r8_excl: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o));

    // R8: expiry of the budget counter while sending ends the attempt
    a_r8_expire: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND) && bud_last |=> timeout_o && !frame_valid_o);

endmodule

// File: tb/test_snd_tx.sv
module test_snd_tx;
    localparam int CLK_PER = 10;
    localparam int BUD     = 50;
    localparam int AW      = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid_i = 1'b0;
    logic [7:0] temp_i = '0;
    logic [7:0] key_i = '0;
    logic       beacon_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       ser_o, frame_valid_o, done_o, timeout_o;

    int nvec = 0;
    int nerr = 0;
    bit finished = 0;

    always #(CLK_PER / 2) clk = ~clk;

    snd_tx #(.BUDGET(BUD), .ACK_WAIT(AW)) i_snd_tx (
        .clk (clk), .rst (rst), .in_valid_i (in_valid_i), .temp_i (temp_i),
        .key_i (key_i), .beacon_i (beacon_i), .ack_i (ack_i), .ser_o (ser_o),
        .frame_valid_o (frame_valid_o), .done_o (done_o), .timeout_o (timeout_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    // Expected frame by long division of {m, 8'h00} by 0x107
    function automatic logic [15:0] exp_frame(input logic [7:0] d, input logic [7:0] k);
        logic [15:0] r;
        logic [7:0]  m;
        m = d ^ k;
        r = {m, 8'h00};
        for (int i = 15; i >= 8; i--)
            if (r[i]) r[i-:9] = r[i-:9] ^ 9'h107;
        return {m, r[7:0]};
    endfunction

    task automatic load_data(input logic [7:0] d, input logic [7:0] k);
        in_valid_i = 1'b1; temp_i = d; key_i = k;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    task automatic fire_beacon;
        beacon_i = 1'b1;
        @(negedge clk);
        beacon_i = 1'b0;
    endtask

    // Collect 16 bit times starting at the current negedge; ack pulsed at index ack_at
    task automatic grab(input string rq, input logic [15:0] exp, input int ack_at);
        logic [15:0] got;
        int          fv;
        got = '0; fv = 0;
        for (int j = 0; j < 16; j++) begin
            got[15-j] = ser_o;
            fv += int'(frame_valid_o);
            chk({rq, " no done while sending"}, {31'd0, done_o}, 32'd0);
            ack_i = (j == ack_at);
            @(negedge clk);
            ack_i = 1'b0;
        end
        chk({rq, " frame bits"}, {16'd0, got}, {16'd0, exp});
        chk({rq, " frame_valid count"}, fv, 16);
    endtask

    task automatic send_and_ack(input string rq, input logic [7:0] d, input logic [7:0] k);
        load_data(d, k);
        fire_beacon();
        grab(rq, exp_frame(d, k), -1);
        chk("R5 ser low after frame", {31'd0, ser_o}, 32'd0);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk("R6 done pulse", {31'd0, done_o}, 32'd1);
        chk("R6 idle after ack", {31'd0, frame_valid_o}, 32'd0);
        @(negedge clk);
        chk("R6 done one cycle", {31'd0, done_o}, 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 ser", {31'd0, ser_o}, 32'd0);
        chk("R1 frame_valid", {31'd0, frame_valid_o}, 32'd0);
        chk("R1 done", {31'd0, done_o}, 32'd0);
        chk("R1 timeout", {31'd0, timeout_o}, 32'd0);
    endtask

    task automatic t_beacon_gate;
        int fv;
        fv = 0;
        beacon_i = 1'b1;
        repeat (5) begin @(negedge clk); fv += int'(frame_valid_o); end
        beacon_i = 1'b0;
        chk("R2 beacon in idle ignored", fv, 0);
        load_data(8'h33, 8'h0F);
        fv = 0;
        repeat (12) begin @(negedge clk); fv += int'(frame_valid_o); end
        chk("R2 no send before beacon", fv, 0);
        fire_beacon();
        grab("R2", exp_frame(8'h33, 8'h0F), -1);
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        chk("R6 done after gated frame", {31'd0, done_o}, 32'd1);
        @(negedge clk);
    endtask

    task automatic t_patterns;
        send_and_ack("R3 R4 R5 pat1", 8'h5A, 8'h3C);
        send_and_ack("R3 R4 R5 pat2", 8'hFF, 8'h00);
        send_and_ack("R3 R4 R5 pat3", 8'h00, 8'h81);
        send_and_ack("R4 zero body", 8'h12, 8'h12);
    endtask

    task automatic t_ack_in_send;
        load_data(8'hA7, 8'h19);
        fire_beacon();
        grab("R6 ack while sending", exp_frame(8'hA7, 8'h19), 5);
        chk("R6 ack in send ignored", {31'd0, done_o}, 32'd0);
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        chk("R6 later ack honoured", {31'd0, done_o}, 32'd1);
        @(negedge clk);
    endtask

    task automatic t_resend;
        int fv;
        load_data(8'hC4, 8'h5E);
        fire_beacon();
        grab("R7 first", exp_frame(8'hC4, 8'h5E), -1);
        fv = 0;
        repeat (AW) begin fv += int'(frame_valid_o); @(negedge clk); end
        chk("R7 silent window", fv, 0);
        grab("R7 resent", exp_frame(8'hC4, 8'h5E), -1);
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        chk("R7 done after resend", {31'd0, done_o}, 32'd1);
        @(negedge clk);
    endtask

    task automatic t_timeout;
        int fv, early;
        fv = 0; early = 0;
        load_data(8'h6B, 8'h2D);
        fire_beacon();
        for (int j = 0; j < BUD; j++) begin
            fv    += int'(frame_valid_o);
            early += int'(timeout_o);
            @(negedge clk);
        end
        chk("R8 no early timeout", early, 0);
        chk("R8 bit times before expiry", fv, 42);
        chk("R8 timeout pulse", {31'd0, timeout_o}, 32'd1);
        chk("R8 idle at expiry", {31'd0, frame_valid_o}, 32'd0);
        chk("R8 no done", {31'd0, done_o}, 32'd0);
        @(negedge clk);
        chk("R8 timeout one cycle", {31'd0, timeout_o}, 32'd0);
    endtask

    task automatic t_busy_ignore;
        load_data(8'h81, 8'h42);
        load_data(8'hFE, 8'h01);
        repeat (2) @(negedge clk);
        fire_beacon();
        in_valid_i = 1'b1; temp_i = 8'h55; key_i = 8'hAA;
        grab("R9 strobe while busy", exp_frame(8'h81, 8'h42), -1);
        in_valid_i = 1'b0;
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_mid;
        int fv;
        load_data(8'h99, 8'h11);
        fire_beacon();
        repeat (5) @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R1 reset mid-frame", {31'd0, frame_valid_o}, 32'd0);
        fv = 0;
        fire_beacon();
        repeat (4) begin fv += int'(frame_valid_o); @(negedge clk); end
        chk("R1 idle after reset", fv, 0);
        send_and_ack("R1 after reset", 8'h3E, 8'hC1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_beacon_gate();
        t_patterns();
        t_ack_in_send();
        t_resend();
        t_timeout();
        t_busy_ignore();
        t_reset_mid();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule